// File: doc/BRIEF.md
# Shadowed Interrupt Aggregator with End-of-Interrupt Re-arm

This block gathers the interrupt events of a USB OTG controller into one 32-bit source register. Each transmit endpoint, receive endpoint and core bus event line has a fixed bit position in that register. The VBUS-drive change event is one of the core lines. A source bit latches on the rising edge of its line and holds until software clears it.

Software works on the source and on an enable mask only through write-one aliases. One alias sets bits and one clears them, for the source and for the mask alike. A read-only register shows the source ANDed with the mask.

A single interrupt output goes high for one cycle when the masked source is nonzero and the block is armed. It stays low after that until software writes the end-of-interrupt register. The block also decodes a control write that produces a one-cycle soft-reset strobe for the attached controller. It offers a fixed revision word and a status view of the raw event lines.

Top module: `irqShadowTop`

## Requirements
- R1: Offset 0x00 reads the fixed nonzero identifier 0x00524501. Writes to it have no effect.
- R2: After reset the source and the mask are zero, the interrupt output is low, the soft-reset strobe is low, and the block is armed.
- R3: Source positions are fixed. Transmit lines sit at bits 4:0, receive lines at bits 12:9, and core lines at bits 24:16, with the VBUS-drive event at bit 24. A rising edge on a line sets its bit and the bit stays set. All other bits always read 0 and cannot be set.
- R4: A line that is held high sets its bit only once. After the bit is cleared, it stays clear until the line falls and rises again.
- R5: Ones written to offset 0x24 set source bits, and ones written to 0x28 clear them. Zero bits leave the source unchanged. Offset 0x20 reads the source.
- R6: Ones written to offset 0x30 set mask bits, and ones written to 0x34 clear them. Offset 0x2C reads the mask.
- R7: Offset 0x38 reads the source ANDed with the mask. Writing to it changes neither the source nor the mask.
- R8: When a rising edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: The interrupt output is high for exactly one cycle when the masked source is nonzero and the block is armed. It then stays low while the masked source remains nonzero.
- R10: A write of any data to offset 0x3C re-arms the block, so a still-pending masked source raises the interrupt output in the next cycle.
- R11: A write with bit 0 set to offset 0x04 produces a one-cycle soft-reset pulse in the cycle after the write. A write with bit 0 clear produces no pulse. Offset 0x04 reads 0.
- R12: Offset 0x08 reads the present levels of the event lines, placed at their source positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Write enable, one write per asserted cycle |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr, combinational |
| txEvt | input | 5 | Transmit endpoint event lines |
| rxEvt | input | 4 | Receive endpoint event lines |
| coreEvt | input | 9 | Core bus event lines; the top bit is the VBUS-drive event |
| softReset | output | 1 | One-cycle soft-reset strobe for the controller |
| irqOut | output | 1 | Interrupt output |

## Verification
The bench targets the gate between the interrupt and the end-of-interrupt write. A design that leaves the output high, or raises it again without a re-arm, shows a high level in the cycles after the first pulse. A design that ignores the re-arm never shows a second pulse.

It drives a line rise in the same cycle as a clear of that bit. A design that gives the clear priority loses the event.

It holds a line high across a clear. A level-sensitive design sets the bit again.

It writes to the reserved bit positions and to the read-only addresses. A design without the valid-bit filter, or with a loose decoder, exposes phantom bits or a corrupted mask.

// File: rtl/irq_shadow_pkg.sv
package irq_shadow_pkg;

  localparam int DATA_W = 32;

  localparam int unsigned OFF_REV      = 'h00;
  localparam int unsigned OFF_CTRL     = 'h04;
  localparam int unsigned OFF_STATUS   = 'h08;
  localparam int unsigned OFF_SRC      = 'h20;
  localparam int unsigned OFF_SRC_SET  = 'h24;
  localparam int unsigned OFF_SRC_CLR  = 'h28;
  localparam int unsigned OFF_MSK      = 'h2C;
  localparam int unsigned OFF_MSK_SET  = 'h30;
  localparam int unsigned OFF_MSK_CLR  = 'h34;
  localparam int unsigned OFF_MASKED   = 'h38;
  localparam int unsigned OFF_EOI      = 'h3C;

  // Write strobes handed from the decoder to the datapath.
  typedef struct packed {
    logic srcSet;
    logic srcClr;
    logic mskSet;
    logic mskClr;
    logic eoi;
    logic softRst;
  } regStrobes_t;

  // Bits that carry an event; everything else is reserved.
  function automatic logic [DATA_W-1:0] eventBits(int txN, int rxN, int rxLsb,
                                                  int coreN, int coreLsb);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < txN; i++)   m[i] = 1'b1;
    for (int i = 0; i < rxN; i++)   m[rxLsb + i] = 1'b1;
    for (int i = 0; i < coreN; i++) m[coreLsb + i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irqShadowCtrl.sv
module irqShadowCtrl
  import irq_shadow_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [DATA_W-1:0] REV_ID = 32'h0052_4501
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              wdataBit0,
  input  logic [DATA_W-1:0] srcQ,
  input  logic [DATA_W-1:0] mskQ,
  input  logic [DATA_W-1:0] lineLevels,
  output regStrobes_t       strobes,
  output logic [DATA_W-1:0] regRdata
);

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned off);
    return a == ADDR_W'(off);
  endfunction

  // Write decode
  always_comb begin
    strobes.srcSet  = regWe && hit(regAddr, OFF_SRC_SET);
    strobes.srcClr  = regWe && hit(regAddr, OFF_SRC_CLR);
    strobes.mskSet  = regWe && hit(regAddr, OFF_MSK_SET);
    strobes.mskClr  = regWe && hit(regAddr, OFF_MSK_CLR);
    strobes.eoi     = regWe && hit(regAddr, OFF_EOI);
    strobes.softRst = regWe && hit(regAddr, OFF_CTRL) && wdataBit0;
  end

  // Read mux; write-only aliases, control and EOI read as zero
  always_comb begin
    regRdata = '0;
    if (hit(regAddr, OFF_REV))    regRdata = REV_ID;
    if (hit(regAddr, OFF_STATUS)) regRdata = lineLevels;
    if (hit(regAddr, OFF_SRC))    regRdata = srcQ;
    if (hit(regAddr, OFF_MSK))    regRdata = mskQ;
    if (hit(regAddr, OFF_MASKED)) regRdata = srcQ & mskQ;
  end

endmodule

// File: rtl/irqShadowDatapath.sv
module irqShadowDatapath
  import irq_shadow_pkg::*;
#(
  parameter logic [DATA_W-1:0] VALID_BITS = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] evtVec,
  output logic [DATA_W-1:0] srcQ,
  output logic [DATA_W-1:0] mskQ,
  output logic              softResetQ,
  output logic              irqOut
);

  logic [DATA_W-1:0] prevEvt;
  logic [DATA_W-1:0] riseBits, setBits, clrBits, mSetBits, mClrBits;
  logic              armedQ;

  always_comb begin
    riseBits = evtVec & ~prevEvt & VALID_BITS;
    setBits  = strobes.srcSet ? (wdata & VALID_BITS) : '0;
    clrBits  = strobes.srcClr ? wdata : '0;
    mSetBits = strobes.mskSet ? (wdata & VALID_BITS) : '0;
    mClrBits = strobes.mskClr ? wdata : '0;
  end

  assign irqOut = armedQ && |(srcQ & mskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevEvt    <= '0;
      srcQ       <= '0;
      mskQ       <= '0;
      armedQ     <= 1'b1;
      softResetQ <= 1'b0;
    end else begin
      prevEvt    <= evtVec;
      srcQ       <= (srcQ & ~clrBits) | setBits | riseBits;
      mskQ       <= (mskQ & ~mClrBits) | mSetBits;
      softResetQ <= strobes.softRst;
      if (strobes.eoi)  armedQ <= 1'b1;
      else if (irqOut)  armedQ <= 1'b0;
    end
  end

endmodule

// File: rtl/irqShadowTop.sv
module irqShadowTop
  import irq_shadow_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TX_N     = 5,
  parameter int RX_N     = 4,
  parameter int RX_LSB   = 9,
  parameter int CORE_N   = 9,
  parameter int CORE_LSB = 16,
  parameter logic [31:0] REV_ID = 32'h0052_4501
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [TX_N-1:0]   txEvt,
  input  logic [RX_N-1:0]   rxEvt,
  input  logic [CORE_N-1:0] coreEvt,
  output logic              softReset,
  output logic              irqOut
);

  localparam logic [DATA_W-1:0] VALID_BITS =
    eventBits(TX_N, RX_N, RX_LSB, CORE_N, CORE_LSB);

  logic [DATA_W-1:0] evtVec, srcQ, mskQ;
  regStrobes_t       strobes;

  always_comb begin
    evtVec = '0;
    evtVec[TX_N-1:0]          = txEvt;
    evtVec[RX_LSB +: RX_N]    = rxEvt;
    evtVec[CORE_LSB +: CORE_N] = coreEvt;
  end

  irqShadowCtrl #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) ctrl_i (
    .regAddr   (regAddr),
    .regWe     (regWe),
    .wdataBit0 (regWdata[0]),
    .srcQ      (srcQ),
    .mskQ      (mskQ),
    .lineLevels(evtVec),
    .strobes   (strobes),
    .regRdata  (regRdata)
  );

  irqShadowDatapath #(.VALID_BITS(VALID_BITS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wdata     (regWdata),
    .evtVec    (evtVec),
    .srcQ      (srcQ),
    .mskQ      (mskQ),
    .softResetQ(softReset),
    .irqOut    (irqOut)
  );

endmodule

// File: rtl/irqShadowChecker.sv
module irqShadowChecker #(
  parameter int ADDR_W = 8,
  parameter logic [31:0] REV_ID = 32'h0052_4501,
  parameter logic [31:0] VALID_BITS = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              softReset,
  input logic              irqOut
);

  logic eoiWrite, ctrlKick, waitEoi;

  assign eoiWrite = regWe && (regAddr == ADDR_W'('h3C));
  assign ctrlKick = regWe && (regAddr == ADDR_W'('h04)) && regWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         waitEoi <= 1'b0;
    else if (eoiWrite) waitEoi <= 1'b0;
    else if (irqOut)   waitEoi <= 1'b1;
  end

  assert_rev_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h00)) |-> (regRdata == REV_ID));

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'('h20)) |-> ((regRdata & ~VALID_BITS) == 32'h0));

  assert_one_cycle_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !eoiWrite) |=> !irqOut);

  assert_quiet_until_eoi_R10: assert property (@(posedge clk) disable iff (!rstN)
    waitEoi |-> !irqOut);

  assert_softrst_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    softReset |-> $past(ctrlKick));

endmodule

bind irqShadowTop irqShadowChecker #(
  .ADDR_W(ADDR_W), .REV_ID(REV_ID), .VALID_BITS(VALID_BITS)
) chk_i (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .softReset(softReset),
  .irqOut(irqOut)
);

// File: tb/irqShadowTop_tb_top.sv
module irqShadowTop_tb_top;

  localparam logic [31:0] REV = 32'h0052_4501;

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read-and-compare, 2 event pulse
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 8'h00, 32'h0,         REV,           4'd1},  // R1
    '{2'd1, 8'h20, 32'h0,         32'h0,         4'd2},  // R2
    '{2'd1, 8'h2C, 32'h0,         32'h0,         4'd2},  // R2
    '{2'd0, 8'h24, 32'hFFFF_FFFF, 32'h0,         4'd5},
    '{2'd1, 8'h20, 32'h0,         32'h01FF_1E1F, 4'd3},  // R3 R5
    '{2'd1, 8'h38, 32'h0,         32'h0,         4'd7},  // R7
    '{2'd0, 8'h30, 32'h0001_0203, 32'h0,         4'd6},
    '{2'd1, 8'h2C, 32'h0,         32'h0001_0203, 4'd6},  // R6
    '{2'd1, 8'h38, 32'h0,         32'h0001_0203, 4'd7},  // R7
    '{2'd0, 8'h28, 32'h0000_0201, 32'h0,         4'd5},
    '{2'd1, 8'h20, 32'h0,         32'h01FF_1C1E, 4'd5},  // R5
    '{2'd1, 8'h38, 32'h0,         32'h0001_0002, 4'd7},  // R7
    '{2'd0, 8'h38, 32'hFFFF_FFFF, 32'h0,         4'd7},
    '{2'd1, 8'h2C, 32'h0,         32'h0001_0203, 4'd7},  // R7
    '{2'd0, 8'h00, 32'h0,         32'h0,         4'd1},
    '{2'd1, 8'h00, 32'h0,         REV,           4'd1},  // R1
    '{2'd0, 8'h34, 32'h0000_0003, 32'h0,         4'd6},
    '{2'd1, 8'h2C, 32'h0,         32'h0001_0200, 4'd6},  // R6
    '{2'd0, 8'h28, 32'hFFFF_FFFF, 32'h0,         4'd5},
    '{2'd1, 8'h20, 32'h0,         32'h0,         4'd5},  // R5
    '{2'd2, 8'h00, 32'h0100_0202, 32'h0,         4'd3},
    '{2'd1, 8'h20, 32'h0,         32'h0100_0202, 4'd3},  // R3
    '{2'd0, 8'h28, 32'h0100_0202, 32'h0,         4'd5}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [4:0]  txEvt = '0;
  logic [3:0]  rxEvt = '0;
  logic [8:0]  coreEvt = '0;
  logic        softReset, irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irqShadowTop dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .txEvt(txEvt),
    .rxEvt(rxEvt), .coreEvt(coreEvt), .softReset(softReset), .irqOut(irqOut)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    #1;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic drive(logic [31:0] v);
    txEvt = v[4:0]; rxEvt = v[12:9]; coreEvt = v[24:16];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R2: reset state of the outputs
    check("R2", {30'h0, irqOut, softReset}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        2'd0: wr(VECS[i].addr, VECS[i].data);
        2'd1: begin
          rd(VECS[i].addr, r);
          check($sformatf("R%0d", VECS[i].req), r, VECS[i].exp);
        end
        default: begin
          @(negedge clk); drive(VECS[i].data);
          @(negedge clk); drive(32'h0);
        end
      endcase
    end

    // R3: reserved bit positions cannot be set
    wr(8'h24, 32'hFE00_E1E0);
    rd(8'h20, r); check("R3", r, 32'h0);

    // R9 / R10: one pulse, then silence until end-of-interrupt
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0);
    wr(8'h24, 32'h0000_0001);
    check("R9", {31'h0, irqOut}, 32'h1);
    @(negedge clk); #1;
    check("R9", {31'h0, irqOut}, 32'h0);
    r = '0;
    for (int k = 0; k < 4; k++) begin @(negedge clk); #1; r[0] = r[0] | irqOut; end
    check("R9", r, 32'h0);
    wr(8'h3C, 32'hDEAD_BEEF);
    check("R10", {31'h0, irqOut}, 32'h1);
    @(negedge clk); #1;
    check("R10", {31'h0, irqOut}, 32'h0);

    // R8: rise on tx bit 1 in the same cycle as its clear
    @(negedge clk);
    txEvt = 5'b00010; regAddr = 8'h28; regWdata = 32'h2; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    rd(8'h20, r); check("R8", r, 32'h0000_0003);

    // R4: held-high line does not set the bit again after a clear
    wr(8'h28, 32'h2);
    rd(8'h20, r); check("R4", r, 32'h0000_0001);

    // R12: status shows the line levels
    coreEvt = 9'h100;
    rd(8'h08, r); check("R12", r, 32'h0100_0002);
    drive(32'h0);
    rd(8'h08, r); check("R12", r, 32'h0);

    // R11: soft-reset strobe
    wr(8'h04, 32'h1);
    check("R11", {31'h0, softReset}, 32'h1);
    @(negedge clk); #1;
    check("R11", {31'h0, softReset}, 32'h0);
    wr(8'h04, 32'h2);
    check("R11", {31'h0, softReset}, 32'h0);
    rd(8'h04, r); check("R11", r, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule